// File: doc/BRIEF.md
# Boundary-Scan Pad Register Chain

This block is the boundary-scan data register for a row of bidirectional pads. It sits between the core logic and the pad drivers. An external test access port controller supplies the state decodes for capture, shift and update, together with the test clock and serial data. Every pad owns exactly three scan cells, whether the pad is bonded or not. One cell observes or drives the pad input value. One holds the pad output value. One holds the output enable. The scan chain is therefore always three cells per pad long.

Each cell has two parts. The first is a shift stage that is clocked on the rising test clock. The second is an update stage that loads on the falling test clock while the update decode is high, so it holds steady while a later shift is in progress. A mode select chooses between normal operation and test operation. In normal operation the pads and the core are connected straight through. In test operation the pad output, the pad enable and the value seen by the core all come from the update stage. Capture and shift run in either mode. As a result, values can be preloaded into the update stage before test mode is entered, without disturbing normal traffic.

Top module: `bscan_io_chain`

## Requirements
- R1: The chain is 3*N_PADS cells long. For pad p, chain bit 3p is the input cell, bit 3p+1 is the output-value cell and bit 3p+2 is the output-enable cell. Bit 0 is nearest `tdo`, and `tdi` enters at bit 3*N_PADS-1.
- R2: On a rising `tck` with `cap_dr` high, every input cell loads `pad_in[p]`, every output cell loads `core_out[p]` and every enable cell loads `core_oe[p]`, all in parallel.
- R3: On a rising `tck` with `shift_dr` high and `cap_dr` low, the chain moves one place toward `tdo` and `tdi` enters bit 3*N_PADS-1. After 3*N_PADS shifts, the chain holds the shifted-in word with its first bit at bit 0.
- R4: `tdo` changes only on the falling `tck`. It presents chain bit 0 while `shift_dr` is high and is 0 otherwise.
- R5: On a falling `tck` with `upd_dr` high, the update stage loads the whole chain. At all other times it holds its value, including throughout any capture or shift.
- R6: With `test_mode` high, `pad_out[p]` equals update bit 3p+1, `pad_oe[p]` equals update bit 3p+2 and `core_in[p]` equals update bit 3p.
- R7: With `test_mode` low, `pad_out`, `pad_oe` and `core_in` follow `core_out`, `core_oe` and `pad_in`, even while the update stage is being loaded (preload).
- R8: A synchronous active-high `rst` clears the chain, the update stage and `tdo` to 0.
- R9: With none of `cap_dr`, `shift_dr` and `upd_dr` high, the chain keeps its contents from one `tck` to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_dr | input | 1 | Capture state decode |
| shift_dr | input | 1 | Shift state decode |
| upd_dr | input | 1 | Update state decode |
| test_mode | input | 1 | 1 = pads and core input driven from the update stage |
| tdi | input | 1 | Serial scan data in |
| tdo | output | 1 | Serial scan data out, falling-edge timed |
| core_out | input | N_PADS | Output values from the core |
| core_oe | input | N_PADS | Output enables from the core |
| core_in | output | N_PADS | Input values delivered to the core |
| pad_in | input | N_PADS | Values received from the pads |
| pad_out | output | N_PADS | Output values to the pad drivers |
| pad_oe | output | N_PADS | Output enables to the pad drivers |

## Verification
Two functions can overlap in one stretch of cycles: a shift of new data through the chain, and pads being driven in test mode from the update stage. The bench latches one pattern and enters test mode. It then shifts a different pattern through the whole chain and samples `pad_out` and `pad_oe` after every bit. Both must stay at the first pattern until the update edge, and after that edge they must show the second pattern. A second overlap is a preload in normal mode. Here the bench checks that the pads keep following the core while the update stage loads, and that the preloaded values appear only once test mode is selected.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int CELLS_PER_PAD = 3;

    // Position of a cell inside its pad's group of three chain bits.
    typedef enum int unsigned {
        CELL_IN  = 0,
        CELL_OUT = 1,
        CELL_OE  = 2
    } cell_e;

    // Data register control decodes from the TAP controller.
    typedef struct packed {
        logic cap;
        logic shift;
        logic upd;
    } dr_ctl_t;

    function automatic int cell_idx(input int pad, input cell_e c);
        return pad * CELLS_PER_PAD + int'(c);
    endfunction

endpackage

// File: rtl/bscan_shift_chain.sv
// Shift stage of the chain. Rising tck: capture has priority over shift.
// Bit order per pad p: 3p input, 3p+1 output value, 3p+2 output enable.
module bscan_shift_chain
    import bscan_pkg::*;
#(
    parameter int N_PADS = 4,
    localparam int LEN = N_PADS * CELLS_PER_PAD
) (
    input  logic              tck,
    input  logic              rst,
    input  dr_ctl_t           ctl,
    input  logic              tdi,
    input  logic [N_PADS-1:0] pad_in,
    input  logic [N_PADS-1:0] core_out,
    input  logic [N_PADS-1:0] core_oe,
    output logic [LEN-1:0]    chain
);

    logic [LEN-1:0] observed;

    for (genvar p = 0; p < N_PADS; p++) begin : g_obs
        assign observed[cell_idx(p, CELL_IN)]  = pad_in[p];
        assign observed[cell_idx(p, CELL_OUT)] = core_out[p];
        assign observed[cell_idx(p, CELL_OE)]  = core_oe[p];
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            chain <= '0;
        end else if (ctl.cap) begin
            chain <= observed;
        end else if (ctl.shift) begin
            chain <= {tdi, chain[LEN-1:1]};
        end
    end

endmodule

// File: rtl/bscan_update_bank.sv
// Update stage: loads while tck goes low in the update state, else holds.
module bscan_update_bank
    import bscan_pkg::*;
#(
    parameter int N_PADS = 4,
    localparam int LEN = N_PADS * CELLS_PER_PAD
) (
    input  logic           tck,
    input  logic           rst,
    input  dr_ctl_t        ctl,
    input  logic [LEN-1:0] chain,
    output logic [LEN-1:0] held
);

    always_ff @(negedge tck) begin
        if (rst) begin
            held <= '0;
        end else if (ctl.upd) begin
            held <= chain;
        end
    end

endmodule

// File: rtl/bscan_pad_mux.sv
// Selects pad and core-input sources between core logic and update stage.
module bscan_pad_mux
    import bscan_pkg::*;
#(
    parameter int N_PADS = 4,
    localparam int LEN = N_PADS * CELLS_PER_PAD
) (
    input  logic              test_mode,
    input  logic [LEN-1:0]    held,
    input  logic [N_PADS-1:0] core_out,
    input  logic [N_PADS-1:0] core_oe,
    input  logic [N_PADS-1:0] pad_in,
    output logic [N_PADS-1:0] pad_out,
    output logic [N_PADS-1:0] pad_oe,
    output logic [N_PADS-1:0] core_in
);

    for (genvar p = 0; p < N_PADS; p++) begin : g_pad
        always_comb begin
            if (test_mode) begin
                pad_out[p] = held[cell_idx(p, CELL_OUT)];
                pad_oe[p]  = held[cell_idx(p, CELL_OE)];
                core_in[p] = held[cell_idx(p, CELL_IN)];
            end else begin
                pad_out[p] = core_out[p];
                pad_oe[p]  = core_oe[p];
                core_in[p] = pad_in[p];
            end
        end
    end

endmodule

// File: rtl/bscan_io_chain.sv
// Boundary-scan register for N_PADS pads, three cells each.
// Chain order: bit 0 nearest tdo (pad 0 input cell), tdi enters bit 3*N_PADS-1.
// Per pad p: bit 3p input, bit 3p+1 output value, bit 3p+2 output enable.
module bscan_io_chain
    import bscan_pkg::*;
#(
    parameter int N_PADS = 4
) (
    input  logic              tck,
    input  logic              rst,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              upd_dr,
    input  logic              test_mode,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_PADS-1:0] core_out,
    input  logic [N_PADS-1:0] core_oe,
    output logic [N_PADS-1:0] core_in,
    input  logic [N_PADS-1:0] pad_in,
    output logic [N_PADS-1:0] pad_out,
    output logic [N_PADS-1:0] pad_oe
);

    localparam int LEN = N_PADS * CELLS_PER_PAD;

    dr_ctl_t        ctl;
    logic [LEN-1:0] chain;
    logic [LEN-1:0] held;

    assign ctl = '{cap: cap_dr, shift: shift_dr, upd: upd_dr};

    bscan_shift_chain #(.N_PADS(N_PADS)) u_chain (
        .tck(tck), .rst(rst), .ctl(ctl), .tdi(tdi),
        .pad_in(pad_in), .core_out(core_out), .core_oe(core_oe),
        .chain(chain)
    );

    bscan_update_bank #(.N_PADS(N_PADS)) u_upd (
        .tck(tck), .rst(rst), .ctl(ctl), .chain(chain), .held(held)
    );

    bscan_pad_mux #(.N_PADS(N_PADS)) u_mux (
        .test_mode(test_mode), .held(held),
        .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in)
    );

    // Serial output is retimed to the falling edge and quiet outside shift.
    always_ff @(negedge tck) begin
        if (rst) begin
            tdo <= 1'b0;
        end else begin
            tdo <= shift_dr ? chain[0] : 1'b0;
        end
    end

endmodule

// File: rtl/bscan_io_chain_chk.sv
module bscan_io_chain_chk #(
    parameter int N_PADS = 4
) (
    input logic              tck,
    input logic              rst,
    input logic              cap_dr,
    input logic              shift_dr,
    input logic              upd_dr,
    input logic              test_mode,
    input logic              tdo,
    input logic [N_PADS-1:0] core_out,
    input logic [N_PADS-1:0] core_oe,
    input logic [N_PADS-1:0] core_in,
    input logic [N_PADS-1:0] pad_in,
    input logic [N_PADS-1:0] pad_out,
    input logic [N_PADS-1:0] pad_oe
);

    // R4: serial output is quiet whenever the chain is not shifting
    p_tdo_quiet_r4: assert property (@(posedge tck) disable iff (rst)
        !shift_dr |-> (tdo == 1'b0));

    // R5: driven pads hold through capture/shift when no update occurred
    p_pads_hold_r5: assert property (@(posedge tck) disable iff (rst)
        (test_mode && $past(test_mode) && !upd_dr)
            |-> ($stable(pad_out) && $stable(pad_oe) && $stable(core_in)));

    // R7: normal mode passes core and pad values straight through
    p_normal_pass_r7: assert property (@(posedge tck) disable iff (rst)
        !test_mode |-> (pad_out == core_out && pad_oe == core_oe && core_in == pad_in));

    // R2: TAP decodes are mutually exclusive states
    p_ctl_excl_r2: assert property (@(posedge tck) disable iff (rst)
        $onehot0({cap_dr, shift_dr, upd_dr}));

endmodule

bind bscan_io_chain bscan_io_chain_chk #(.N_PADS(N_PADS)) chk_i (
    .tck(tck), .rst(rst), .cap_dr(cap_dr), .shift_dr(shift_dr),
    .upd_dr(upd_dr), .test_mode(test_mode), .tdo(tdo),
    .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
);

// File: tb/bscan_io_chain_tb_top.sv
module bscan_io_chain_tb_top;

    localparam int N   = 4;
    localparam int LEN = 3 * N;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic cap_dr = 1'b0, shift_dr = 1'b0, upd_dr = 1'b0;
    logic test_mode = 1'b0, tdi = 1'b0;
    logic tdo;
    logic [N-1:0] core_out = '0, core_oe = '0, pad_in = '0;
    logic [N-1:0] core_in, pad_out, pad_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 tck = ~tck;   // 125 MHz

    bscan_io_chain #(.N_PADS(N)) dut_i (
        .tck(tck), .rst(rst), .cap_dr(cap_dr), .shift_dr(shift_dr),
        .upd_dr(upd_dr), .test_mode(test_mode), .tdi(tdi), .tdo(tdo),
        .core_out(core_out), .core_oe(core_oe), .core_in(core_in),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // Vector fields: [23:20] pad_in, [19:16] core_out, [15:12] core_oe, [11:0] scan-in word
    localparam logic [23:0] VEC [5] = '{
        24'hA5C_3C9, 24'h0F0_FFF, 24'h936_000, 24'h5A5_A5A, 24'hF0F_123
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic tick();
        @(posedge tck); #1;
    endtask

    function automatic logic [LEN-1:0] cap_word(input logic [N-1:0] pi,
                                                input logic [N-1:0] co,
                                                input logic [N-1:0] coe);
        logic [LEN-1:0] w;
        for (int p = 0; p < N; p++) begin
            w[3*p]   = pi[p];
            w[3*p+1] = co[p];
            w[3*p+2] = coe[p];
        end
        return w;
    endfunction

    function automatic logic [3*N-1:0] pads_of(input logic [LEN-1:0] w);
        logic [N-1:0] o, e, c;
        for (int p = 0; p < N; p++) begin
            c[p] = w[3*p];
            o[p] = w[3*p+1];
            e[p] = w[3*p+2];
        end
        return {o, e, c};
    endfunction

    task automatic do_capture();
        cap_dr = 1'b1; tick(); cap_dr = 1'b0;
    endtask

    task automatic do_shift(input logic [LEN-1:0] din, output logic [LEN-1:0] dout);
        shift_dr = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            tdi = din[i];
            @(negedge tck); #1;
            dout[i] = tdo;
            tick();
        end
        shift_dr = 1'b0;
    endtask

    task automatic do_update();
        upd_dr = 1'b1; tick(); upd_dr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [LEN-1:0] got;
        logic [LEN-1:0] a_word, b_word;
        // R8: reset state
        test_mode = 1'b1;
        repeat (3) tick();
        check("R8 pads after reset", {pad_out, pad_oe, core_in}, '0);
        check("R8 tdo after reset", tdo, 0);
        rst = 1'b0;
        test_mode = 1'b0;
        tick();
        do_shift('0, got);
        check("R8 chain cleared", got, '0);

        // Vector table: capture, shift, preload, then test mode
        for (int v = 0; v < 5; v++) begin
            pad_in   = VEC[v][23:20];
            core_out = VEC[v][19:16];
            core_oe  = VEC[v][15:12];
            tick();
            check("R7 normal pass", {pad_out, pad_oe, core_in}, {core_out, core_oe, pad_in});
            do_capture();
            do_shift(VEC[v][11:0], got);
            check("R2 R3 captured word on tdo", got, cap_word(pad_in, core_out, core_oe));
            @(negedge tck); #1;
            check("R4 tdo idle", tdo, 0);
            tick();
            do_update();
            check("R7 preload keeps pads on core", {pad_out, pad_oe, core_in},
                  {core_out, core_oe, pad_in});
            test_mode = 1'b1; #1;
            check("R6 pads from update stage", {pad_out, pad_oe, core_in}, pads_of(VEC[v][11:0]));
            tick();
            test_mode = 1'b0;
        end

        // R1: single set bit at pad 2 output cell (bit 7)
        do_shift(12'h080, got);
        do_update();
        test_mode = 1'b1; #1;
        check("R1 cell order pad2 out", {pad_out, pad_oe, core_in}, {4'b0100, 4'b0000, 4'b0000});
        test_mode = 1'b0;

        // R9: chain holds while idle
        pad_in = 4'h6; core_out = 4'h9; core_oe = 4'h3;
        do_capture();
        pad_in = 4'h0; core_out = 4'hF; core_oe = 4'hC;
        repeat (3) tick();
        do_shift('0, got);
        check("R9 idle hold", got, cap_word(4'h6, 4'h9, 4'h3));

        // R5: shift during test-mode drive leaves pads alone until update
        a_word = 12'hC35; b_word = 12'h3CA;
        do_shift(a_word, got);
        do_update();
        test_mode = 1'b1;
        tick();
        do_capture();
        shift_dr = 1'b1;
        for (int i = 0; i < LEN; i++) begin
            tdi = b_word[i];
            tick();
            check("R5 pads stable during shift", {pad_out, pad_oe, core_in}, pads_of(a_word));
        end
        shift_dr = 1'b0;
        tick();
        check("R5 pads held before update", {pad_out, pad_oe, core_in}, pads_of(a_word));
        do_update();
        check("R5 pads after update", {pad_out, pad_oe, core_in}, pads_of(b_word));
        test_mode = 1'b0;

        // R8: reset mid-operation clears update stage
        rst = 1'b1; tick(); tick(); rst = 1'b0;
        test_mode = 1'b1; #1;
        check("R8 reset clears update stage", {pad_out, pad_oe, core_in}, '0);
        test_mode = 1'b0;
        tick();

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule